// File: doc/BRIEF.md
# I2C Bus Line Integrity Monitor

This block sits next to an I2C host engine and watches the synchronized SCL and SDA samples. For debug it keeps a rolling record of the last sixteen samples of each line. It also reports four kinds of bus trouble, each as a one-cycle pulse. A target may stretch the clock for too long. Another device may pull SCL low in the middle of a clock pulse. Another device may pull SDA low while the host has let it go. SDA may change while SCL is high during a receive bit.

The host engine supplies context on each cycle. It reports whether it is monitoring at all and whether it has released SCL and SDA. It also reports whether it is receiving a data or ACK bit, and whether the current SCL high pulse has already begun. A low SCL seen before the pulse begins counts as clock stretching and feeds only the timeout counter. The same low seen after the pulse has begun is reported as interference. Software supplies a 31-bit timeout limit and an enable for the timeout.

Top module: `i2c_line_monitor`

## Requirements
- R1: After reset, every bit of `lineHistory` is 1 and all four event outputs are 0.
- R2: On every clock edge `lineHistory[15:0]` shifts left and takes the current SCL sample in bit 0, with the oldest SCL sample in bit 15. `lineHistory[31:16]` does the same for SDA, with the newest sample in bit 16 and the oldest in bit 31. This happens whether or not `hostActive` is set.
- R3: When `stretchEn` is 1, `evStretchTimeout` is high for exactly one cycle, in the cycle after the edge that samples the (`stretchLimit`+1)-th consecutive cycle in which SCL is low while the host releases it.
- R4: The low-time count restarts from zero on any cycle in which SCL is sampled high, or in which the host is itself driving SCL low (`hostSclRelease` = 0).
- R5: When `stretchEn` is 0, `evStretchTimeout` never fires.
- R6: SCL going low while `sclPulseStarted` is 0 does not raise `evSclInterference`.
- R7: When SCL falls (high on the previous sample, low on the current one) while the host releases SCL and `sclPulseStarted` is 1, `evSclInterference` is high for one cycle, in the cycle after that edge.
- R8: `evSdaInterference` pulses for one cycle on the first sampled cycle in which the host releases SDA, SDA is low and `hostReceiving` is 0. It pulses again only after that condition has cleared and come back.
- R9: While `hostReceiving` is 1, any SDA sample that differs from the previous sample raises a one-cycle `evSdaUnstable` pulse, provided SCL was high on both samples.
- R10: SDA edges while SCL is high and `hostReceiving` is 0 raise no event. This covers START and STOP.
- R11: While `hostActive` is 0, no event fires and the low-time count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostActive | input | 1 | Host engine is running; enables monitoring |
| sclIn | input | 1 | Synchronized SCL sample |
| sdaIn | input | 1 | Synchronized SDA sample |
| hostSclRelease | input | 1 | Host is not driving SCL low |
| hostSdaRelease | input | 1 | Host is not driving SDA low |
| hostReceiving | input | 1 | Host is receiving a data or ACK bit |
| sclPulseStarted | input | 1 | The current SCL high pulse has begun |
| stretchEn | input | 1 | Enables the stretch timeout |
| stretchLimit | input | 31 | Permitted low-time in clock ticks |
| lineHistory | output | 32 | SCL history in bits 15:0, SDA history in bits 31:16, newest sample at the low end of each half |
| evStretchTimeout | output | 1 | Stretch timeout pulse |
| evSclInterference | output | 1 | SCL interference pulse |
| evSdaInterference | output | 1 | SDA interference pulse |
| evSdaUnstable | output | 1 | SDA instability pulse |

## Verification
The bench sweeps several small timeout limits, including zero, and checks every cycle. An off-by-one comparison would show up as a pulse one cycle early or late, and a missing saturation or re-arm would show up as a repeated pulse. It breaks a low stretch once by driving SCL high and once by letting the host drive SCL, so a counter that fails to restart would fire too soon. It pulls SCL low both before and after the pulse start, so a design that confused stretching with interference would be caught. It drives SDA edges under a high SCL both in receive and in START/STOP context, and also drives an SDA change that lands on the rising SCL edge, which would expose a stability check that looked at only one SCL sample.

// File: rtl/lmon_pkg.sv
package lmon_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } lmonStrobe_t;

  // state from datapath back to control
  typedef struct packed {
    logic prevScl;
    logic prevSda;
    logic cntAtLimit;
  } lmonStatus_t;
endpackage

// File: rtl/lmon_datapath.sv
module lmon_datapath
  import lmon_pkg::*;
#(
  parameter int HIST_DEPTH = 16,
  parameter int LIMIT_W    = 31
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  lmonStrobe_t               strobe,
  input  logic [LIMIT_W-1:0]        stretchLimit,
  output logic [2*HIST_DEPTH-1:0]   lineHistory,
  output lmonStatus_t               status
);
  localparam int CNT_W = LIMIT_W + 1;
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] lineSample;
  assign lineSample = {sdaIn, sclIn};

  // one shift register per line; line 0 = SCL, line 1 = SDA
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [HIST_DEPTH-1:0] hist;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hist <= '1;
      else       hist <= {hist[HIST_DEPTH-2:0], lineSample[g]};
    end
    assign lineHistory[g*HIST_DEPTH +: HIST_DEPTH] = hist;
  end

  // low-time counter, one bit wider than the limit so it can saturate past it
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                lowCnt <= '0;
    else if (strobe.cntClear)                 lowCnt <= '0;
    else if (strobe.cntInc && (lowCnt != '1)) lowCnt <= lowCnt + 1'b1;
  end

  assign status.prevScl    = lineHistory[0];
  assign status.prevSda    = lineHistory[HIST_DEPTH];
  assign status.cntAtLimit = (lowCnt == {1'b0, stretchLimit});
endmodule

// File: rtl/lmon_ctrl.sv
module lmon_ctrl
  import lmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostActive,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        hostSclRelease,
  input  logic        hostSdaRelease,
  input  logic        hostReceiving,
  input  logic        sclPulseStarted,
  input  logic        stretchEn,
  input  lmonStatus_t status,
  output lmonStrobe_t strobe,
  output logic        evStretchTimeout,
  output logic        evSclInterference,
  output logic        evSdaInterference,
  output logic        evSdaUnstable
);
  logic sclHeldByOther;
  logic stretchHit;
  logic sclIntfHit;
  logic sdaIntfCond;
  logic sdaIntfSeen;
  logic sdaIntfHit;
  logic unstableHit;

  // SCL low while the host lets it float: another device holds it
  assign sclHeldByOther = hostActive & hostSclRelease & ~sclIn;

  always_comb begin
    strobe          = '0;
    strobe.cntInc   = sclHeldByOther;
    strobe.cntClear = ~sclHeldByOther;
  end

  assign stretchHit  = sclHeldByOther & stretchEn & status.cntAtLimit;
  // a fall inside a pulse that has begun is interference, not stretching
  assign sclIntfHit  = sclHeldByOther & sclPulseStarted & status.prevScl;
  assign sdaIntfCond = hostActive & hostSdaRelease & ~hostReceiving & ~sdaIn;
  assign sdaIntfHit  = sdaIntfCond & ~sdaIntfSeen;
  assign unstableHit = hostActive & hostReceiving & sclIn & status.prevScl &
                       (sdaIn != status.prevSda);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaIntfSeen       <= 1'b0;
      evStretchTimeout  <= 1'b0;
      evSclInterference <= 1'b0;
      evSdaInterference <= 1'b0;
      evSdaUnstable     <= 1'b0;
    end else begin
      sdaIntfSeen       <= sdaIntfCond;
      evStretchTimeout  <= stretchHit;
      evSclInterference <= sclIntfHit;
      evSdaInterference <= sdaIntfHit;
      evSdaUnstable     <= unstableHit;
    end
  end
endmodule

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor
  import lmon_pkg::*;
#(
  parameter int HIST_DEPTH = 16,
  parameter int LIMIT_W    = 31
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostActive,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  logic                    hostSclRelease,
  input  logic                    hostSdaRelease,
  input  logic                    hostReceiving,
  input  logic                    sclPulseStarted,
  input  logic                    stretchEn,
  input  logic [LIMIT_W-1:0]      stretchLimit,
  output logic [2*HIST_DEPTH-1:0] lineHistory,
  output logic                    evStretchTimeout,
  output logic                    evSclInterference,
  output logic                    evSdaInterference,
  output logic                    evSdaUnstable
);
  lmonStrobe_t strobe;
  lmonStatus_t status;

  lmon_ctrl u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .hostActive       (hostActive),
    .sclIn            (sclIn),
    .sdaIn            (sdaIn),
    .hostSclRelease   (hostSclRelease),
    .hostSdaRelease   (hostSdaRelease),
    .hostReceiving    (hostReceiving),
    .sclPulseStarted  (sclPulseStarted),
    .stretchEn        (stretchEn),
    .status           (status),
    .strobe           (strobe),
    .evStretchTimeout (evStretchTimeout),
    .evSclInterference(evSclInterference),
    .evSdaInterference(evSdaInterference),
    .evSdaUnstable    (evSdaUnstable)
  );

  lmon_datapath #(
    .HIST_DEPTH(HIST_DEPTH),
    .LIMIT_W   (LIMIT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .strobe      (strobe),
    .stretchLimit(stretchLimit),
    .lineHistory (lineHistory),
    .status      (status)
  );
endmodule

// File: rtl/lmon_checker.sv
module lmon_checker #(
  parameter int HIST_DEPTH = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    hostActive,
  input logic                    sclIn,
  input logic                    hostSclRelease,
  input logic                    hostReceiving,
  input logic                    sclPulseStarted,
  input logic                    stretchEn,
  input logic [2*HIST_DEPTH-1:0] lineHistory,
  input logic                    evStretchTimeout,
  input logic                    evSclInterference,
  input logic                    evSdaInterference,
  input logic                    evSdaUnstable
);
  a_r2_scl_shift: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> lineHistory[HIST_DEPTH-1:1] == $past(lineHistory[HIST_DEPTH-2:0]));

  a_r2_scl_newest: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> lineHistory[0] == $past(sclIn));

  a_r3_timeout_single: assert property (@(posedge clk) disable iff (!rstN)
    evStretchTimeout |=> !evStretchTimeout);

  a_r5_timeout_enabled: assert property (@(posedge clk) disable iff (!rstN)
    !stretchEn |=> !evStretchTimeout);

  a_r6_no_intf_before_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !sclPulseStarted |=> !evSclInterference);

  a_r7_intf_on_low: assert property (@(posedge clk) disable iff (!rstN)
    evSclInterference |-> ($past(hostSclRelease) && !$past(sclIn)));

  a_r8_sda_intf_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evSdaInterference |=> !evSdaInterference);

  a_r10_unstable_needs_rx: assert property (@(posedge clk) disable iff (!rstN)
    !hostReceiving |=> !evSdaUnstable);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !hostActive |=> !(evStretchTimeout || evSclInterference ||
                      evSdaInterference || evSdaUnstable));
endmodule

bind i2c_line_monitor lmon_checker #(.HIST_DEPTH(HIST_DEPTH)) u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .hostActive       (hostActive),
  .sclIn            (sclIn),
  .hostSclRelease   (hostSclRelease),
  .hostReceiving    (hostReceiving),
  .sclPulseStarted  (sclPulseStarted),
  .stretchEn        (stretchEn),
  .lineHistory      (lineHistory),
  .evStretchTimeout (evStretchTimeout),
  .evSclInterference(evSclInterference),
  .evSdaInterference(evSdaInterference),
  .evSdaUnstable    (evSdaUnstable)
);

// File: tb/i2c_line_monitor_tb.sv
module i2c_line_monitor_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostActive = 1'b0;
  logic        sclIn = 1'b1;
  logic        sdaIn = 1'b1;
  logic        hostSclRelease = 1'b0;
  logic        hostSdaRelease = 1'b0;
  logic        hostReceiving = 1'b0;
  logic        sclPulseStarted = 1'b0;
  logic        stretchEn = 1'b0;
  logic [30:0] stretchLimit = '0;
  logic [31:0] lineHistory;
  logic        evStretchTimeout, evSclInterference, evSdaInterference, evSdaUnstable;

  int checks = 0;
  int errors = 0;
  logic [15:0] expScl = '1;
  logic [15:0] expSda = '1;

  always #5 clk = ~clk;

  i2c_line_monitor u_dut (
    .clk(clk), .rstN(rstN), .hostActive(hostActive), .sclIn(sclIn), .sdaIn(sdaIn),
    .hostSclRelease(hostSclRelease), .hostSdaRelease(hostSdaRelease),
    .hostReceiving(hostReceiving), .sclPulseStarted(sclPulseStarted),
    .stretchEn(stretchEn), .stretchLimit(stretchLimit), .lineHistory(lineHistory),
    .evStretchTimeout(evStretchTimeout), .evSclInterference(evSclInterference),
    .evSdaInterference(evSdaInterference), .evSdaUnstable(evSdaUnstable)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, then check history (R2) and the event vector
  // ev order: {stretch, sclIntf, sdaIntf, unstable}
  task automatic step(input logic scl, input logic sda, input logic [3:0] ev, input string req);
    @(negedge clk);
    sclIn = scl;
    sdaIn = sda;
    @(posedge clk);
    #1;
    expScl = {expScl[14:0], scl};
    expSda = {expSda[14:0], sda};
    check("R2 history", lineHistory, {expSda, expScl});
    check(req, {28'd0, evStretchTimeout, evSclInterference, evSdaInterference, evSdaUnstable},
          {28'd0, ev});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    // R1 reset state
    check("R1 history", lineHistory, 32'hFFFF_FFFF);
    check("R1 events", {28'd0, evStretchTimeout, evSclInterference, evSdaInterference, evSdaUnstable}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R2/R11 history sweep with monitoring off and every hazard input set
    hostActive = 0; hostSclRelease = 1; hostSdaRelease = 1; sclPulseStarted = 1;
    stretchEn = 1; stretchLimit = 0;
    for (int i = 0; i < 40; i++)
      step(i[0] ^ i[2], i[1] ^ i[3], 4'b0000, "R11 idle no event");

    // R3 sweep over small limits, including zero
    hostActive = 1; hostSclRelease = 1; hostSdaRelease = 0; sclPulseStarted = 0;
    hostReceiving = 0; stretchEn = 1;
    for (int lim = 0; lim < 5; lim++) begin
      stretchLimit = 31'(lim);
      step(1, 1, 4'b0000, "R3 prep");
      for (int k = 1; k <= lim + 3; k++)
        step(0, 1, (k == lim + 1) ? 4'b1000 : 4'b0000, "R3 timeout position");
    end

    // R5 disabled
    stretchEn = 0; stretchLimit = 1;
    step(1, 1, 4'b0000, "R5 prep");
    for (int k = 0; k < 5; k++) step(0, 1, 4'b0000, "R5 disabled");

    // R4 restart by SCL high and by host driving SCL
    stretchEn = 1; stretchLimit = 3;
    step(1, 1, 4'b0000, "R4 prep");
    for (int k = 0; k < 3; k++) step(0, 1, 4'b0000, "R4 before high");
    step(1, 1, 4'b0000, "R4 high clears");
    for (int k = 0; k < 3; k++) step(0, 1, 4'b0000, "R4 after high");
    hostSclRelease = 0;
    step(0, 1, 4'b0000, "R4 host drives");
    hostSclRelease = 1;
    for (int k = 0; k < 3; k++) step(0, 1, 4'b0000, "R4 after host drive");
    step(0, 1, 4'b1000, "R4 fires on fourth");

    // R6 stretch before pulse, R7 interference within pulse
    stretchEn = 0;
    step(1, 1, 4'b0000, "R6 prep");
    step(0, 1, 4'b0000, "R6 stretch is legal");
    sclPulseStarted = 1;
    step(1, 1, 4'b0000, "R7 high");
    step(0, 1, 4'b0100, "R7 interference");
    step(0, 1, 4'b0000, "R7 single pulse");

    // R8 SDA interference
    sclPulseStarted = 0; hostSclRelease = 0; hostSdaRelease = 1; hostReceiving = 0;
    step(0, 1, 4'b0000, "R8 prep");
    step(0, 0, 4'b0010, "R8 pulled low");
    step(0, 0, 4'b0000, "R8 single pulse");
    step(0, 1, 4'b0000, "R8 released");
    step(0, 0, 4'b0010, "R8 rearmed");
    hostReceiving = 1;
    step(0, 1, 4'b0000, "R8 rx prep");
    step(0, 0, 4'b0000, "R8 receive exempt");

    // R9 SDA stability during receive
    step(0, 1, 4'b0000, "R9 prep");
    step(1, 0, 4'b0000, "R9 change at rising edge");
    step(1, 0, 4'b0000, "R9 steady");
    step(1, 1, 4'b0001, "R9 unstable rise");
    step(1, 0, 4'b0001, "R9 unstable fall");
    step(1, 0, 4'b0000, "R9 steady again");
    step(0, 1, 4'b0000, "R9 scl low change");

    // R10 START/STOP not flagged
    hostReceiving = 0; hostSdaRelease = 0;
    step(1, 1, 4'b0000, "R10 prep");
    step(1, 0, 4'b0000, "R10 START");
    step(1, 1, 4'b0000, "R10 STOP");

    // R11 active low clears and silences stretch
    stretchEn = 1; stretchLimit = 0; hostSclRelease = 1; hostActive = 0;
    for (int k = 0; k < 3; k++) step(0, 1, 4'b0000, "R11 idle stretch");
    hostActive = 1;
    step(0, 1, 4'b1000, "R11 count from zero");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule